// File: doc/BRIEF.md
# Programming-Mode Address Counter and Flash Controller

This block is the target-side engine of a serial programming mode. An upstream deserializer turns pin traffic into one-cycle command strobes and a 14-bit data word. This block owns the 14-bit programming address counter and acts on those strobes against a behavioural model of the on-chip nonvolatile store. The store holds user program words, four identification words, a configuration word whose bit 6 is the code-protect enable, and a bank of calibration words. Flash timing is modelled as cycle counts. A busy flag is high while an erase or program operation runs.

The counter can only move forward. Its top bit selects the configuration region and stays set once set, so only a mode entry brings the counter back to user space. Erase reach and write protection both depend on where the counter points when the command arrives. Writes never erase first, so a program operation can only clear bits.

Top module: `pgm_flash_ctrl`

## Requirements
- R1: After rstN is low, or one cycle after an enterMode strobe, the counter is 0x0000 and busy is 0. After rstN, readData is 0 and every cell reads 0x3FFF (erased).
- R2: In user space (counter bit 13 = 0), an increment from 0x1FFF wraps to 0x0000. User words are USER_WORDS deep, and addresses alias modulo USER_WORDS.
- R3: loadCfg sets the counter to 0x2000 and latches dataIn as the pending word for that address. While bit 13 is set, increments wrap 0x3FFF to 0x2000, and bit 13 stays set until enterMode.
- R4: beginProg followed by the programming time writes old AND latched data to the addressed cell. A beginProg with no load since the last commit or mode entry is ignored, and busy stays 0.
- R5: loadData fills latch slot counter[1:0]. In user space, a commit writes every filled slot into the aligned four-word block that holds the counter, all at once. Nothing reaches memory before the commit.
- R6: Programming keeps busy high for exactly PROG_CYCLES cycles, and an erase keeps it high for ERASE_CYCLES cycles. Strobes other than enterMode are ignored while busy. After programming ends, only endProg or enterMode is accepted.
- R7: Bulk erase sets all user words and the configuration word to 0x3FFF. It also erases the four identification words only when the counter is exactly 0x2000. Calibration words are never erased.
- R8: Row erase sets to 0x3FFF the 16 user words whose index shares counter bits above bit 3. It is ignored, with busy staying 0, when protection is active or bit 13 is set.
- R9: When configuration-word bit 6 is 0 (protection active), user-space reads return 0 and user-space commits do not change memory. Identification and configuration words still read and program normally.
- R10: The configuration map repeats every 256 words. Offsets 0x00 to 0x03 hold identification words, offset 0x07 holds the configuration word, and offsets 0x80 onward hold CAL_WORDS calibration words. Every other offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset; returns the store to the erased state |
| enterMode | input | 1 | Mode entry: clears the counter, the latch and any operation in flight |
| loadCfg | input | 1 | Jump to configuration space and latch dataIn |
| loadData | input | 1 | Latch dataIn into the slot chosen by counter bits [1:0] |
| readCmd | input | 1 | Capture the addressed word into readData |
| incAddr | input | 1 | Advance the counter |
| beginProg | input | 1 | Start committing the latched words |
| endProg | input | 1 | Close a finished programming operation |
| bulkErase | input | 1 | Erase the whole store, with reach set by the counter |
| rowErase | input | 1 | Erase one 16-word user row |
| dataIn | input | 14 | Word for load commands |
| readData | output | 14 | Last captured read value |
| busy | output | 1 | An erase or program operation is in progress |

## Verification
The bench targets the counter's two wrap points. A counter that lost its sticky top bit would land back in user space after 0x3FFF, and would then return a user word where the first identification word is expected. It also checks that a four-word load stays invisible until the commit and then appears as a block, and that a second write ANDs with the first instead of replacing it. A design that erased before writing would show the second value alone. Erase reach is probed from user space, from 0x2000 and against calibration words. Row erase must stop exactly at the 16-word boundary and must do nothing under protection. The busy windows are measured in cycles, and an increment sent during them must leave no trace in a later read.

// File: rtl/pgm_pkg.sv
package pgm_pkg;
  localparam int WORD_W = 14;
  localparam int ADDR_W = 14;
  localparam logic [WORD_W-1:0] ERASED = 14'h3FFF;
  localparam logic [ADDR_W-1:0] CFG_BASE = 14'h2000;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PROG,
    ST_WAITEND,
    ST_ERASE
  } ctrl_state_t;

  typedef struct packed {
    logic clear;
    logic loadCfg;
    logic loadData;
    logic read;
    logic incr;
    logic commitProg;
    logic commitBulk;
    logic commitRow;
  } dp_ops_t;
endpackage

// File: rtl/pgm_ctrl.sv
module pgm_ctrl
  import pgm_pkg::*;
#(
  parameter int PROG_CYCLES  = 16,
  parameter int ERASE_CYCLES = 24
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    enterMode,
  input  logic    loadCfg,
  input  logic    loadData,
  input  logic    readCmd,
  input  logic    incAddr,
  input  logic    beginProg,
  input  logic    endProg,
  input  logic    bulkErase,
  input  logic    rowErase,
  input  logic    loadPending,
  input  logic    inCfg,
  input  logic    cpActive,
  output dp_ops_t ops,
  output logic    busy
);
  localparam int MAXC  = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int CNT_W = $clog2(MAXC + 1);

  ctrl_state_t state, nState;
  logic [CNT_W-1:0] cnt, nCnt;
  logic kindBulk, nKindBulk;

  always_comb begin
    ops       = '0;
    nState    = state;
    nCnt      = cnt;
    nKindBulk = kindBulk;
    if (enterMode) begin
      ops.clear = 1'b1;
      nState    = ST_IDLE;
      nCnt      = '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (loadCfg)       ops.loadCfg  = 1'b1;
          else if (loadData) ops.loadData = 1'b1;
          else if (readCmd)  ops.read     = 1'b1;
          else if (incAddr)  ops.incr     = 1'b1;
          else if (beginProg) begin
            if (loadPending) begin
              nState = ST_PROG;
              nCnt   = CNT_W'(PROG_CYCLES - 1);
            end
          end else if (bulkErase) begin
            nState    = ST_ERASE;
            nKindBulk = 1'b1;
            nCnt      = CNT_W'(ERASE_CYCLES - 1);
          end else if (rowErase) begin
            if (!inCfg && !cpActive) begin
              nState    = ST_ERASE;
              nKindBulk = 1'b0;
              nCnt      = CNT_W'(ERASE_CYCLES - 1);
            end
          end
        end
        ST_PROG: begin
          if (cnt == '0) begin
            ops.commitProg = 1'b1;
            nState         = ST_WAITEND;
          end else begin
            nCnt = cnt - 1'b1;
          end
        end
        ST_WAITEND: begin
          if (endProg) nState = ST_IDLE;
        end
        ST_ERASE: begin
          if (cnt == '0) begin
            ops.commitBulk = kindBulk;
            ops.commitRow  = !kindBulk;
            nState         = ST_IDLE;
          end else begin
            nCnt = cnt - 1'b1;
          end
        end
        default: nState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      kindBulk <= 1'b0;
    end else begin
      state    <= nState;
      cnt      <= nCnt;
      kindBulk <= nKindBulk;
    end
  end

  assign busy = (state == ST_PROG) || (state == ST_ERASE);
endmodule

// File: rtl/pgm_datapath.sv
module pgm_datapath
  import pgm_pkg::*;
#(
  parameter int USER_WORDS = 1024,
  parameter int CAL_WORDS  = 11,
  parameter int CP_BIT     = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_ops_t           ops,
  input  logic [WORD_W-1:0] dataIn,
  output logic [ADDR_W-1:0] pc,
  output logic [WORD_W-1:0] readData,
  output logic              loadPending,
  output logic              inCfg,
  output logic              cpActive
);
  localparam int IDX_W     = $clog2(USER_WORDS);
  localparam int CAL_IDX_W = (CAL_WORDS > 1) ? $clog2(CAL_WORDS) : 1;

  logic [WORD_W-1:0] userMem [USER_WORDS];
  logic [WORD_W-1:0] idWords [4];
  logic [WORD_W-1:0] calMem  [CAL_WORDS];
  logic [WORD_W-1:0] cfgWord;
  logic [WORD_W-1:0] latchWord [4];
  logic [3:0]        latchValid;

  logic [7:0]           cfgOff;
  logic [7:0]           calOff;
  logic [1:0]           slot;
  logic                 isId, isCfgW, isCal;
  logic [CAL_IDX_W-1:0] calIdx;
  logic [WORD_W-1:0]    cfgRd, rdVal;
  logic [ADDR_W-1:0]    nextPc;

  assign cfgOff      = pc[7:0];
  assign slot        = pc[1:0];
  assign calOff      = cfgOff - 8'h80;
  assign calIdx      = calOff[CAL_IDX_W-1:0];
  assign isId        = (cfgOff < 8'd4);
  assign isCfgW      = (cfgOff == 8'd7);
  assign isCal       = ({1'b0, cfgOff} >= 9'h080) && ({1'b0, cfgOff} < 9'(128 + CAL_WORDS));
  assign inCfg       = pc[ADDR_W-1];
  assign cpActive    = ~cfgWord[CP_BIT];
  assign loadPending = |latchValid;
  assign nextPc      = {pc[ADDR_W-1], pc[ADDR_W-2:0] + 13'd1};

  always_comb begin
    if (isId)        cfgRd = idWords[cfgOff[1:0]];
    else if (isCfgW) cfgRd = cfgWord;
    else if (isCal)  cfgRd = calMem[calIdx];
    else             cfgRd = '0;
    if (inCfg)         rdVal = cfgRd;
    else if (cpActive) rdVal = '0;
    else               rdVal = userMem[pc[IDX_W-1:0]];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc         <= '0;
      readData   <= '0;
      cfgWord    <= ERASED;
      latchValid <= '0;
      for (int i = 0; i < USER_WORDS; i++) userMem[i] <= ERASED;
      for (int i = 0; i < CAL_WORDS; i++)  calMem[i]  <= ERASED;
      for (int i = 0; i < 4; i++) begin
        idWords[i]   <= ERASED;
        latchWord[i] <= '0;
      end
    end else if (ops.clear) begin
      pc         <= '0;
      latchValid <= '0;
    end else begin
      if (ops.loadCfg) begin
        pc           <= CFG_BASE;
        latchWord[0] <= dataIn;
        latchValid   <= 4'b0001;
      end
      if (ops.loadData) begin
        latchWord[slot]  <= dataIn;
        latchValid[slot] <= 1'b1;
      end
      if (ops.incr) pc <= nextPc;
      if (ops.read) readData <= rdVal;
      if (ops.commitProg) begin
        latchValid <= '0;
        if (inCfg) begin
          if (latchValid[slot]) begin
            if (isId)        idWords[cfgOff[1:0]] <= idWords[cfgOff[1:0]] & latchWord[slot];
            else if (isCfgW) cfgWord <= cfgWord & latchWord[slot];
            else if (isCal)  calMem[calIdx] <= calMem[calIdx] & latchWord[slot];
          end
        end else if (!cpActive) begin
          for (int s = 0; s < 4; s++) begin
            if (latchValid[s])
              userMem[{pc[IDX_W-1:2], 2'(s)}] <= userMem[{pc[IDX_W-1:2], 2'(s)}] & latchWord[s];
          end
        end
      end
      if (ops.commitBulk) begin
        for (int i = 0; i < USER_WORDS; i++) userMem[i] <= ERASED;
        cfgWord <= ERASED;
        if (pc == CFG_BASE) begin
          for (int i = 0; i < 4; i++) idWords[i] <= ERASED;
        end
      end
      if (ops.commitRow) begin
        for (int r = 0; r < 16; r++) userMem[{pc[IDX_W-1:4], 4'(r)}] <= ERASED;
      end
    end
  end
endmodule

// File: rtl/pgm_flash_ctrl.sv
module pgm_flash_ctrl
  import pgm_pkg::*;
#(
  parameter int USER_WORDS   = 1024,
  parameter int CAL_WORDS    = 11,
  parameter int CP_BIT       = 6,
  parameter int PROG_CYCLES  = 16,
  parameter int ERASE_CYCLES = 24
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        enterMode,
  input  logic        loadCfg,
  input  logic        loadData,
  input  logic        readCmd,
  input  logic        incAddr,
  input  logic        beginProg,
  input  logic        endProg,
  input  logic        bulkErase,
  input  logic        rowErase,
  input  logic [13:0] dataIn,
  output logic [13:0] readData,
  output logic        busy
);
  dp_ops_t           ops;
  logic [ADDR_W-1:0] pc;
  logic              loadPending, inCfg, cpActive;

  pgm_ctrl #(
    .PROG_CYCLES (PROG_CYCLES),
    .ERASE_CYCLES(ERASE_CYCLES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .enterMode(enterMode), .loadCfg(loadCfg),
    .loadData(loadData), .readCmd(readCmd), .incAddr(incAddr),
    .beginProg(beginProg), .endProg(endProg), .bulkErase(bulkErase),
    .rowErase(rowErase), .loadPending(loadPending), .inCfg(inCfg),
    .cpActive(cpActive), .ops(ops), .busy(busy)
  );

  pgm_datapath #(
    .USER_WORDS(USER_WORDS),
    .CAL_WORDS (CAL_WORDS),
    .CP_BIT    (CP_BIT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ops(ops), .dataIn(dataIn), .pc(pc),
    .readData(readData), .loadPending(loadPending), .inCfg(inCfg),
    .cpActive(cpActive)
  );
endmodule

// File: rtl/pgm_flash_chk.sv
module pgm_flash_chk #(
  parameter int MAX_BUSY = 24
) (
  input logic        clk,
  input logic        rstN,
  input logic        enterMode,
  input logic        rowErase,
  input logic        busy,
  input logic [13:0] pc,
  input logic [13:0] readData
);
  logic [31:0] busyRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     busyRun <= '0;
    else if (busy) busyRun <= busyRun + 1;
    else           busyRun <= '0;
  end

  // R1: mode entry clears the counter and any operation
  p_enter_clear_r1: assert property (@(posedge clk) disable iff (!rstN)
    enterMode |=> (pc == 14'h0000) && !busy);

  // R2: the counter only steps forward, jumps to 0x2000 or clears
  p_pc_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(pc) |-> (pc == 14'h0000) || (pc == 14'h2000) ||
                     (pc == {$past(pc[13]), $past(pc[12:0]) + 13'd1}));

  // R3: the configuration region bit is sticky
  p_cfg_sticky_r3: assert property (@(posedge clk) disable iff (!rstN)
    pc[13] && !enterMode |=> pc[13]);

  // R6: no counter or read movement while busy
  p_busy_freeze_r6: assert property (@(posedge clk) disable iff (!rstN)
    busy && !enterMode |=> $stable(pc) && $stable(readData));

  // R6: busy window is bounded
  p_busy_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    busyRun <= MAX_BUSY);

  // R8: row erase in configuration space starts nothing
  p_row_cfg_ignored_r8: assert property (@(posedge clk) disable iff (!rstN)
    rowErase && pc[13] && !busy && !enterMode |=> !busy);
endmodule

bind pgm_flash_ctrl pgm_flash_chk #(
  .MAX_BUSY((PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES)
) u_chk (
  .clk(clk), .rstN(rstN), .enterMode(enterMode), .rowErase(rowErase),
  .busy(busy), .pc(pc), .readData(readData)
);

// File: tb/test_pgm_flash_ctrl.sv
module test_pgm_flash_ctrl;
  localparam int UW = 1024;
  localparam int PC_N = 5;
  localparam int EC_N = 7;

  localparam logic [3:0] E = 4'd0, LC = 4'd1, LD = 4'd2, RD = 4'd3, IN = 4'd4,
                         BG = 4'd5, EN = 4'd6, BK = 4'd7, RW = 4'd8;

  typedef struct packed {
    logic [3:0]  op;
    logic [13:0] data;
    logic [15:0] rep;
    logic [13:0] expd;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 85;
  localparam vec_t VECS [NV] = '{
    '{E, 14'h0, 16'd1, 14'h0, 4'd1},
    '{RD, 14'h0, 16'd1, 14'h3FFF, 4'd1},     // R1 erased
    '{LD, 14'h1234, 16'd1, 14'h0, 4'd4},
    '{BG, 14'h0, 16'd1, 14'h0, 4'd4},
    '{EN, 14'h0, 16'd1, 14'h0, 4'd4},
    '{RD, 14'h0, 16'd1, 14'h1234, 4'd4},     // R4 single write
    '{LD, 14'h0F0F, 16'd1, 14'h0, 4'd4},
    '{BG, 14'h0, 16'd1, 14'h0, 4'd4},
    '{EN, 14'h0, 16'd1, 14'h0, 4'd4},
    '{RD, 14'h0, 16'd1, 14'h0204, 4'd4},     // R4 AND with old value
    '{IN, 14'h0, 16'd4, 14'h0, 4'd5},
    '{LD, 14'h0001, 16'd1, 14'h0, 4'd5},
    '{RD, 14'h0, 16'd1, 14'h3FFF, 4'd5},     // R5 not committed yet
    '{IN, 14'h0, 16'd1, 14'h0, 4'd5},
    '{LD, 14'h0002, 16'd1, 14'h0, 4'd5},
    '{IN, 14'h0, 16'd1, 14'h0, 4'd5},
    '{LD, 14'h0003, 16'd1, 14'h0, 4'd5},
    '{IN, 14'h0, 16'd1, 14'h0, 4'd5},
    '{LD, 14'h0004, 16'd1, 14'h0, 4'd5},
    '{BG, 14'h0, 16'd1, 14'h0, 4'd5},
    '{EN, 14'h0, 16'd1, 14'h0, 4'd5},
    '{E, 14'h0, 16'd1, 14'h0, 4'd5},
    '{IN, 14'h0, 16'd4, 14'h0, 4'd5},
    '{RD, 14'h0, 16'd1, 14'h0001, 4'd5},     // R5 block word 0
    '{IN, 14'h0, 16'd1, 14'h0, 4'd5},
    '{RD, 14'h0, 16'd1, 14'h0002, 4'd5},
    '{IN, 14'h0, 16'd1, 14'h0, 4'd5},
    '{RD, 14'h0, 16'd1, 14'h0003, 4'd5},
    '{IN, 14'h0, 16'd1, 14'h0, 4'd5},
    '{RD, 14'h0, 16'd1, 14'h0004, 4'd5},     // R5 block word 3
    '{IN, 14'h0, 16'd9, 14'h0, 4'd8},
    '{LD, 14'h0AAA, 16'd1, 14'h0, 4'd8},
    '{BG, 14'h0, 16'd1, 14'h0, 4'd8},
    '{EN, 14'h0, 16'd1, 14'h0, 4'd8},
    '{E, 14'h0, 16'd1, 14'h0, 4'd8},
    '{IN, 14'h0, 16'd7, 14'h0, 4'd8},
    '{RW, 14'h0, 16'd1, 14'h0, 4'd8},
    '{E, 14'h0, 16'd1, 14'h0, 4'd8},
    '{RD, 14'h0, 16'd1, 14'h3FFF, 4'd8},     // R8 row word 0 erased
    '{IN, 14'h0, 16'd4, 14'h0, 4'd8},
    '{RD, 14'h0, 16'd1, 14'h3FFF, 4'd8},     // R8 row word 4 erased
    '{IN, 14'h0, 16'd12, 14'h0, 4'd8},
    '{RD, 14'h0, 16'd1, 14'h0AAA, 4'd8},     // R8 next row kept
    '{LC, 14'h0006, 16'd1, 14'h0, 4'd3},
    '{BG, 14'h0, 16'd1, 14'h0, 4'd3},
    '{EN, 14'h0, 16'd1, 14'h0, 4'd3},
    '{RD, 14'h0, 16'd1, 14'h0006, 4'd3},     // R3 counter at 0x2000
    '{IN, 14'h0, 16'd1, 14'h0, 4'd10},
    '{RD, 14'h0, 16'd1, 14'h3FFF, 4'd10},    // R10 second id word
    '{IN, 14'h0, 16'd6, 14'h0, 4'd10},
    '{LD, 14'h3FBF, 16'd1, 14'h0, 4'd9},
    '{BG, 14'h0, 16'd1, 14'h0, 4'd9},
    '{EN, 14'h0, 16'd1, 14'h0, 4'd9},
    '{RD, 14'h0, 16'd1, 14'h3FBF, 4'd9},     // R9 config word readable
    '{IN, 14'h0, 16'd1, 14'h0, 4'd10},
    '{RD, 14'h0, 16'd1, 14'h0000, 4'd10},    // R10 reserved reads 0
    '{IN, 14'h0, 16'd120, 14'h0, 4'd10},
    '{LD, 14'h0155, 16'd1, 14'h0, 4'd10},
    '{BG, 14'h0, 16'd1, 14'h0, 4'd10},
    '{EN, 14'h0, 16'd1, 14'h0, 4'd10},
    '{RD, 14'h0, 16'd1, 14'h0155, 4'd10},    // R10 calibration word
    '{IN, 14'h0, 16'd8064, 14'h0, 4'd3},
    '{RD, 14'h0, 16'd1, 14'h0006, 4'd3},     // R3 wrap to 0x2000
    '{E, 14'h0, 16'd1, 14'h0, 4'd9},
    '{RD, 14'h0, 16'd1, 14'h0000, 4'd9},     // R9 protected read
    '{BK, 14'h0, 16'd1, 14'h0, 4'd7},
    '{LC, 14'h3FFF, 16'd1, 14'h0, 4'd7},
    '{RD, 14'h0, 16'd1, 14'h0006, 4'd7},     // R7 ids kept
    '{IN, 14'h0, 16'd7, 14'h0, 4'd7},
    '{RD, 14'h0, 16'd1, 14'h3FFF, 4'd7},     // R7 config erased
    '{E, 14'h0, 16'd1, 14'h0, 4'd9},
    '{RD, 14'h0, 16'd1, 14'h3FFF, 4'd9},     // R9 protection gone
    '{LC, 14'h3FFF, 16'd1, 14'h0, 4'd7},
    '{BK, 14'h0, 16'd1, 14'h0, 4'd7},
    '{RD, 14'h0, 16'd1, 14'h3FFF, 4'd7},     // R7 ids erased at 0x2000
    '{IN, 14'h0, 16'd128, 14'h0, 4'd7},
    '{RD, 14'h0, 16'd1, 14'h0155, 4'd7},     // R7 calibration kept
    '{E, 14'h0, 16'd1, 14'h0, 4'd2},
    '{LD, 14'h0123, 16'd1, 14'h0, 4'd2},
    '{BG, 14'h0, 16'd1, 14'h0, 4'd2},
    '{EN, 14'h0, 16'd1, 14'h0, 4'd2},
    '{IN, 14'h0, 16'(UW), 14'h0, 4'd2},
    '{RD, 14'h0, 16'd1, 14'h0123, 4'd2},     // R2 aliasing
    '{IN, 14'h0, 16'(8192 - UW), 14'h0, 4'd2},
    '{RD, 14'h0, 16'd1, 14'h0123, 4'd2}      // R2 wrap to 0x0000
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enterMode = 0, loadCfg = 0, loadData = 0, readCmd = 0, incAddr = 0;
  logic beginProg = 0, endProg = 0, bulkErase = 0, rowErase = 0;
  logic [13:0] dataIn = '0;
  logic [13:0] readData;
  logic busy;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pgm_flash_ctrl #(
    .USER_WORDS(UW), .CAL_WORDS(11), .CP_BIT(6),
    .PROG_CYCLES(PC_N), .ERASE_CYCLES(EC_N)
  ) i_pgm_flash_ctrl (
    .clk(clk), .rstN(rstN), .enterMode(enterMode), .loadCfg(loadCfg),
    .loadData(loadData), .readCmd(readCmd), .incAddr(incAddr),
    .beginProg(beginProg), .endProg(endProg), .bulkErase(bulkErase),
    .rowErase(rowErase), .dataIn(dataIn), .readData(readData), .busy(busy)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic setStrobe(input logic [3:0] op, input logic v);
    case (op)
      E:  enterMode = v;
      LC: loadCfg   = v;
      LD: loadData  = v;
      RD: readCmd   = v;
      IN: incAddr   = v;
      BG: beginProg = v;
      EN: endProg   = v;
      BK: bulkErase = v;
      RW: rowErase  = v;
      default: ;
    endcase
  endtask

  task automatic doOp(input logic [3:0] op, input logic [13:0] d);
    @(negedge clk);
    dataIn = d;
    setStrobe(op, 1'b1);
    @(negedge clk);
    setStrobe(op, 1'b0);
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    check("R1 busy at reset", int'(busy), 0);
    check("R1 readData at reset", int'(readData), 0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      for (int k = 0; k < int'(VECS[i].rep); k++) doOp(VECS[i].op, VECS[i].data);
      if (VECS[i].op == RD)
        check($sformatf("R%0d vector %0d", VECS[i].req, i), int'(readData), int'(VECS[i].expd));
    end

    // R6: busy length, and an increment sent during busy or after is ignored
    doOp(E, 14'h0);
    doOp(LD, 14'h0103);
    @(negedge clk); beginProg = 1'b1;
    @(negedge clk); beginProg = 1'b0;
    cnt = 0;
    while (busy) begin
      cnt++;
      incAddr = (cnt == 2);
      @(negedge clk);
    end
    incAddr = 1'b0;
    check("R6 program busy cycles", cnt, PC_N);
    doOp(IN, 14'h0);
    doOp(EN, 14'h0);
    doOp(RD, 14'h0);
    check("R6 increments ignored, R4 write", int'(readData), 14'h0103);

    // R6: erase busy length
    doOp(E, 14'h0);
    @(negedge clk); bulkErase = 1'b1;
    @(negedge clk); bulkErase = 1'b0;
    cnt = 0;
    while (busy) begin cnt++; @(negedge clk); end
    check("R6 erase busy cycles", cnt, EC_N);

    // R4: beginProg without a load does nothing
    doOp(E, 14'h0);
    @(negedge clk); beginProg = 1'b1;
    @(negedge clk); beginProg = 1'b0;
    check("R4 begin without load", int'(busy), 0);

    // R8: row erase in configuration space is ignored
    doOp(LC, 14'h3FFF);
    @(negedge clk); rowErase = 1'b1;
    @(negedge clk); rowErase = 1'b0;
    check("R8 row erase in cfg", int'(busy), 0);

    // R8 and R9: set protection, then row erase is ignored
    doOp(IN, 14'h0); doOp(IN, 14'h0); doOp(IN, 14'h0); doOp(IN, 14'h0);
    doOp(IN, 14'h0); doOp(IN, 14'h0); doOp(IN, 14'h0);
    doOp(LD, 14'h3FBF); doOp(BG, 14'h0); doOp(EN, 14'h0);
    doOp(E, 14'h0);
    @(negedge clk); rowErase = 1'b1;
    @(negedge clk); rowErase = 1'b0;
    check("R8 row erase under protection", int'(busy), 0);
    doOp(RD, 14'h0);
    check("R9 protected user read", int'(readData), 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule